// File: doc/BRIEF.md
# Alarm, Snooze and Sleep Controller

This block is the decision logic of a clock radio. It takes the running time and a stored wake-up time, both as hours (0 to 23) and minutes. When the running minute first reaches the wake-up time, it opens a ring window 119 minutes long. During that window it drives a tone output, which is the 900 Hz tone clock gated by a half-second on, half-second off envelope. A snooze button silences the tone for a partial minute plus eight whole minutes, and it can be used again any number of times until the window closes. An alarm-off level ends the window at once.

The same block runs a sleep timer that keeps a radio switched on. A rising edge on the sleep-set level loads the timer with 0:59, or with 1:59 when the long-period select is high. While the set level stays high, the timer runs down one minute per 2 Hz tick, so the user can trim the period. Once the set level is released, the timer runs down one step per minute. The sleep output is high while the timer is not zero. A snooze press always clears the timer. When no alarm is ringing, this is the one-touch way to switch the radio off.

The block detects minute boundaries itself, as any change of the running minute. The timebase, the editing of the wake-up time and the display multiplexing belong to the neighbouring logic.

Top module: `alarm_sleep_ctrl`

## Requirements
- R1: The alarm becomes active only on a minute boundary at which the hours and minutes both equal the wake-up time. The comparison is on a 24-hour basis, so 6:05 does not match 18:05.
- R2: An active alarm ends by itself on the 119th minute boundary after the boundary that started it. It still rings on the 118th.
- R3: While the alarm rings, alarmTone equals toneClk ANDed with a gate. The gate is 0 after reset and flips on every tick2Hz pulse. The output is registered. alarmTone stays 0 whenever the alarm is idle.
- R4: A snooze press, meaning a rising edge of snoozeLvl, mutes an active alarm. The tone comes back on the 9th minute boundary after the press.
- R5: Snooze can be pressed again after the tone has resumed, and the same 9-boundary mute applies each time, as long as the ring window is open.
- R6: A high alarmOffLvl ends an active alarm. Because activation needs the match to begin on a boundary, the alarm does not ring again within the same minute.
- R7: A rising edge of sleepSetLvl loads the sleep timer with 0:59 when sleepLongSel is 0 and with 1:59 when it is 1. The timer is reported as sleepHr (0 or 1) and sleepMin (0 to 59).
- R8: While sleepSetLvl stays high after the load, each tick2Hz pulse lowers the timer by one minute, borrowing from the hour (1:00 becomes 0:59). While sleepSetLvl is low, each minute boundary lowers it by one. The timer never goes below 0:00.
- R9: sleepOut is 1 exactly while the sleep timer is not 0:00.
- R10: A snooze press clears the sleep timer to 0:00, whether or not the alarm is active, unless a sleep load happens in the same cycle.
- R11: During reset and straight after it, alarmTone and sleepOut are 0 and the sleep timer reads 0:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick2Hz | input | 1 | One-cycle pulse, twice per second |
| toneClk | input | 1 | 900 Hz square wave |
| curHour | input | 5 | Running hour, 0 to 23 |
| curMin | input | 6 | Running minute, 0 to 59 |
| almHour | input | 5 | Wake-up hour, 0 to 23 |
| almMin | input | 6 | Wake-up minute, 0 to 59 |
| snoozeLvl | input | 1 | Debounced snooze button level |
| alarmOffLvl | input | 1 | Debounced alarm-off level |
| sleepSetLvl | input | 1 | Sleep-set request level |
| sleepLongSel | input | 1 | Selects the 1:59 sleep period |
| alarmTone | output | 1 | Gated alarm tone |
| sleepOut | output | 1 | Radio-on output of the sleep timer |
| sleepHr | output | 1 | Sleep timer hours |
| sleepMin | output | 6 | Sleep timer minutes |

## Verification
Latency counts from the clock edge after the change. A minute change, a snooze edge or an alarm-off level moves the alarm state on the first edge, and alarmTone follows on the second, because the tone is registered from that state. A sleep load, a sleep step or a snooze clear shows on sleepHr, sleepMin and sleepOut after one edge. The bench changes inputs on falling edges and then waits at least two further falling edges before it samples, so every result is read two to three cycles after the stimulus that caused it.

// File: rtl/asc_pkg.sv
package asc_pkg;
  typedef struct packed {
    logic winClr;
    logic winStep;
    logic snzLoad;
    logic snzStep;
    logic slpLoad;
    logic slpClr;
    logic slpStep;
  } ascStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RING   = 2'd1,
    ST_SNOOZE = 2'd2
  } almState_t;
endpackage

// File: rtl/asc_datapath.sv
module asc_datapath
  import asc_pkg::*;
#(
  parameter int HR_W    = 5,
  parameter int MIN_W   = 6,
  parameter int WIN_MIN = 119,
  parameter int SNZ_MIN = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick2Hz,
  input  logic [HR_W-1:0]  curHour,
  input  logic [MIN_W-1:0] curMin,
  input  logic [HR_W-1:0]  almHour,
  input  logic [MIN_W-1:0] almMin,
  input  logic             snoozeLvl,
  input  logic             sleepSetLvl,
  input  logic             sleepLongSel,
  input  ascStrobe_t       stb,
  output logic             minEdge,
  output logic             timeMatch,
  output logic             winDone,
  output logic             snzLast,
  output logic             snzPress,
  output logic             setRise,
  output logic             sleepNz,
  output logic             gate,
  output logic             sleepHr,
  output logic [MIN_W-1:0] sleepMin
);
  localparam int WIN_W = $clog2(WIN_MIN);
  localparam int SNZ_W = $clog2(SNZ_MIN + 1);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);

  logic [MIN_W-1:0] prevMin;
  logic             primed;
  logic             snzQ;
  logic             setQ;
  logic [WIN_W-1:0] winCnt;
  logic [SNZ_W-1:0] snzCnt;

  assign minEdge   = primed && (curMin != prevMin);
  assign timeMatch = (curHour == almHour) && (curMin == almMin);
  assign winDone   = (winCnt == WIN_W'(WIN_MIN - 1));
  assign snzLast   = (snzCnt == SNZ_W'(1));
  assign snzPress  = snoozeLvl && !snzQ;
  assign setRise   = sleepSetLvl && !setQ;
  assign sleepNz   = sleepHr || (sleepMin != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMin <= '0;
      primed  <= 1'b0;
      snzQ    <= 1'b0;
      setQ    <= 1'b0;
      gate    <= 1'b0;
    end else begin
      prevMin <= curMin;
      primed  <= 1'b1;
      snzQ    <= snoozeLvl;
      setQ    <= sleepSetLvl;
      if (tick2Hz) gate <= !gate;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (stb.winClr) begin
      winCnt <= '0;
    end else if (stb.winStep) begin
      winCnt <= winCnt + WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snzCnt <= '0;
    end else if (stb.snzLoad) begin
      snzCnt <= SNZ_W'(SNZ_MIN);
    end else if (stb.snzStep && snzCnt != '0) begin
      snzCnt <= snzCnt - SNZ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepHr  <= 1'b0;
      sleepMin <= '0;
    end else if (stb.slpLoad) begin
      sleepHr  <= sleepLongSel;
      sleepMin <= MIN_TOP;
    end else if (stb.slpClr) begin
      sleepHr  <= 1'b0;
      sleepMin <= '0;
    end else if (stb.slpStep) begin
      if (sleepMin == '0) begin
        sleepHr  <= 1'b0;
        sleepMin <= MIN_TOP;
      end else begin
        sleepMin <= sleepMin - MIN_W'(1);
      end
    end
  end

  AST_SLEEP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    setRise |=> (sleepMin == MIN_TOP && sleepHr == $past(sleepLongSel))); // R7
  AST_SLEEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    sleepMin <= MIN_TOP); // R8
  AST_SNZ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (snzPress && !setRise) |=> (!sleepNz)); // R10
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_W'(WIN_MIN - 1)); // R2
  AST_SNZ_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    snzCnt <= SNZ_W'(SNZ_MIN)); // R5
endmodule

// File: rtl/asc_control.sv
module asc_control
  import asc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick2Hz,
  input  logic       toneClk,
  input  logic       alarmOffLvl,
  input  logic       sleepSetLvl,
  input  logic       minEdge,
  input  logic       timeMatch,
  input  logic       winDone,
  input  logic       snzLast,
  input  logic       snzPress,
  input  logic       setRise,
  input  logic       sleepNz,
  input  logic       gate,
  output ascStrobe_t stb,
  output logic       alarmTone
);
  almState_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (minEdge && timeMatch && !alarmOffLvl) begin
          nextState  = ST_RING;
          stb.winClr = 1'b1;
        end
      end
      ST_RING, ST_SNOOZE: begin
        stb.winStep = minEdge && !winDone;
        stb.snzStep = minEdge && (state == ST_SNOOZE);
        if (alarmOffLvl) begin
          nextState = ST_IDLE;
        end else if (minEdge && winDone) begin
          nextState = ST_IDLE;
        end else if (snzPress) begin
          nextState   = ST_SNOOZE;
          stb.snzLoad = 1'b1;
        end else if (state == ST_SNOOZE && minEdge && snzLast) begin
          nextState = ST_RING;
        end
      end
      default: nextState = ST_IDLE;
    endcase

    stb.slpLoad = setRise;
    stb.slpClr  = snzPress && !setRise;
    stb.slpStep = !setRise && !snzPress && sleepNz &&
                  (sleepSetLvl ? tick2Hz : minEdge);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      alarmTone <= 1'b0;
    end else begin
      state     <= nextState;
      alarmTone <= (state == ST_RING) && gate && toneClk;
    end
  end

  AST_TONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> !alarmTone); // R3
  AST_SNOOZE_MUTE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SNOOZE) |=> !alarmTone); // R4
  AST_OFF_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    alarmOffLvl |=> (state == ST_IDLE)); // R6
  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !minEdge) |=> (state == ST_IDLE)); // R1
endmodule

// File: rtl/alarm_sleep_ctrl.sv
module alarm_sleep_ctrl
  import asc_pkg::*;
#(
  parameter int HR_W    = 5,
  parameter int MIN_W   = 6,
  parameter int WIN_MIN = 119,
  parameter int SNZ_MIN = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick2Hz,
  input  logic             toneClk,
  input  logic [HR_W-1:0]  curHour,
  input  logic [MIN_W-1:0] curMin,
  input  logic [HR_W-1:0]  almHour,
  input  logic [MIN_W-1:0] almMin,
  input  logic             snoozeLvl,
  input  logic             alarmOffLvl,
  input  logic             sleepSetLvl,
  input  logic             sleepLongSel,
  output logic             alarmTone,
  output logic             sleepOut,
  output logic             sleepHr,
  output logic [MIN_W-1:0] sleepMin
);
  ascStrobe_t stb;
  logic minEdge, timeMatch, winDone, snzLast, snzPress, setRise, sleepNz, gate;

  asc_datapath #(
    .HR_W(HR_W), .MIN_W(MIN_W), .WIN_MIN(WIN_MIN), .SNZ_MIN(SNZ_MIN)
  ) uDp (
    .clk(clk), .rstN(rstN), .tick2Hz(tick2Hz),
    .curHour(curHour), .curMin(curMin), .almHour(almHour), .almMin(almMin),
    .snoozeLvl(snoozeLvl), .sleepSetLvl(sleepSetLvl), .sleepLongSel(sleepLongSel),
    .stb(stb), .minEdge(minEdge), .timeMatch(timeMatch), .winDone(winDone),
    .snzLast(snzLast), .snzPress(snzPress), .setRise(setRise), .sleepNz(sleepNz),
    .gate(gate), .sleepHr(sleepHr), .sleepMin(sleepMin)
  );

  asc_control uCtl (
    .clk(clk), .rstN(rstN), .tick2Hz(tick2Hz), .toneClk(toneClk),
    .alarmOffLvl(alarmOffLvl), .sleepSetLvl(sleepSetLvl),
    .minEdge(minEdge), .timeMatch(timeMatch), .winDone(winDone),
    .snzLast(snzLast), .snzPress(snzPress), .setRise(setRise),
    .sleepNz(sleepNz), .gate(gate), .stb(stb), .alarmTone(alarmTone)
  );

  assign sleepOut = sleepNz;
endmodule

// File: tb/sim_alarm_sleep_ctrl.sv
module sim_alarm_sleep_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick2Hz = 1'b0, toneClk = 1'b0;
  logic [4:0] curHour = 5'd6, almHour = 5'd6;
  logic [5:0] curMin = 6'd28, almMin = 6'd30;
  logic snoozeLvl = 1'b0, alarmOffLvl = 1'b0, sleepSetLvl = 1'b0, sleepLongSel = 1'b0;
  logic alarmTone, sleepOut, sleepHr;
  logic [5:0] sleepMin;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  alarm_sleep_ctrl u0 (
    .clk(clk), .rstN(rstN), .tick2Hz(tick2Hz), .toneClk(toneClk),
    .curHour(curHour), .curMin(curMin), .almHour(almHour), .almMin(almMin),
    .snoozeLvl(snoozeLvl), .alarmOffLvl(alarmOffLvl), .sleepSetLvl(sleepSetLvl),
    .sleepLongSel(sleepLongSel), .alarmTone(alarmTone), .sleepOut(sleepOut),
    .sleepHr(sleepHr), .sleepMin(sleepMin)
  );

  always #10 clk = ~clk;

  localparam logic [1:0] OP_MIN = 2'd0;
  localparam logic [1:0] OP_SNZ = 2'd1;
  localparam logic [1:0] OP_OFF = 2'd2;
  localparam int NV = 24;
  localparam logic [2:0] VEC [NV] = '{
    {OP_MIN,1'b0}, {OP_MIN,1'b1}, {OP_SNZ,1'b0},
    {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0},
    {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0},
    {OP_MIN,1'b1}, {OP_SNZ,1'b0},
    {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0},
    {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0}, {OP_MIN,1'b0},
    {OP_MIN,1'b1}, {OP_OFF,1'b0}, {OP_MIN,1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic advMin();
    @(negedge clk);
    if (curMin == 6'd59) begin
      curMin = 6'd0;
      curHour = (curHour == 5'd23) ? 5'd0 : curHour + 5'd1;
    end else begin
      curMin = curMin + 6'd1;
    end
    waitc(3);
  endtask

  task automatic pulse2Hz();
    @(negedge clk) tick2Hz = 1'b1;
    @(negedge clk) tick2Hz = 1'b0;
    waitc(2);
  endtask

  task automatic pressSnz();
    @(negedge clk) snoozeLvl = 1'b1;
    waitc(2);
    snoozeLvl = 1'b0;
    waitc(2);
  endtask

  task automatic pulseOff();
    @(negedge clk) alarmOffLvl = 1'b1;
    waitc(2);
    alarmOffLvl = 1'b0;
    waitc(3);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitc(3);
    chk("R11 tone in reset", alarmTone, 0);
    chk("R11 sleepOut in reset", sleepOut, 0);
    rstN = 1'b1;
    waitc(3);
    chk("R11 sleep timer after reset", {sleepHr, sleepMin}, 0);
    chk("R11 tone after reset", alarmTone, 0);

    toneClk = 1'b1;
    pulse2Hz();  // gate now 1
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][2:1])
        OP_MIN: advMin();
        OP_SNZ: pressSnz();
        default: pulseOff();
      endcase
      chk($sformatf("R1 R4 R5 R6 vector %0d", i), alarmTone, VEC[i][0]);
    end
    waitc(5);
    chk("R6 no retrigger in same minute", alarmTone, 0);

    // R2 window and R3 gating
    almHour = 5'd7; almMin = 6'd0;
    @(negedge clk) begin curHour = 5'd6; curMin = 6'd59; end
    waitc(3);
    advMin();
    chk("R1 ring at 7:00", alarmTone, 1);
    toneClk = 1'b0; waitc(2);
    chk("R3 tone clock low", alarmTone, 0);
    toneClk = 1'b1; waitc(2);
    chk("R3 tone clock high", alarmTone, 1);
    pulse2Hz();
    chk("R3 gate low", alarmTone, 0);
    pulse2Hz();
    chk("R3 gate high", alarmTone, 1);
    for (int m = 0; m < 118; m++) advMin();
    chk("R2 ringing at minute 118", alarmTone, 1);
    advMin();
    chk("R2 ended at minute 119", alarmTone, 0);

    // R1 24-hour compare
    almHour = 5'd18; almMin = 6'd5;
    @(negedge clk) begin curHour = 5'd6; curMin = 6'd4; end
    waitc(3);
    advMin();
    chk("R1 6:05 vs 18:05", alarmTone, 0);
    @(negedge clk) begin curHour = 5'd18; curMin = 6'd4; end
    waitc(3);
    advMin();
    chk("R1 18:05 match", alarmTone, 1);
    pulseOff();
    chk("R6 alarm off", alarmTone, 0);

    // sleep timer
    sleepLongSel = 1'b0;
    @(negedge clk) sleepSetLvl = 1'b1;
    waitc(2);
    sleepSetLvl = 1'b0;
    waitc(2);
    chk("R7 short load", {sleepHr, sleepMin}, 59);
    chk("R9 sleepOut on", sleepOut, 1);
    advMin();
    chk("R8 minute step", {sleepHr, sleepMin}, 58);
    pressSnz();
    chk("R10 snooze clears timer", {sleepHr, sleepMin}, 0);
    chk("R9 sleepOut off", sleepOut, 0);

    sleepLongSel = 1'b1;
    @(negedge clk) sleepSetLvl = 1'b1;
    waitc(2);
    chk("R7 long load", {sleepHr, sleepMin}, 64 + 59);
    for (int k = 0; k < 60; k++) pulse2Hz();
    chk("R8 borrow 1:00 to 0:59", {sleepHr, sleepMin}, 59);
    for (int k = 0; k < 59; k++) pulse2Hz();
    chk("R8 reached zero", {sleepHr, sleepMin}, 0);
    chk("R9 sleepOut at zero", sleepOut, 0);
    pulse2Hz();
    chk("R8 floor at zero", {sleepHr, sleepMin}, 0);
    sleepSetLvl = 1'b0;
    advMin();
    chk("R8 stays zero after release", {sleepHr, sleepMin}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule